// File: doc/BRIEF.md
# One-Time-Pad Line Encryption Engine

This engine sits between an on-chip cache and untrusted external memory and protects every line that crosses that boundary. A line is stored outside the chip as its plaintext XORed with a pad. The pad is a keyed mix of the line's virtual address and a per-line sequence number. The sequence number changes on every write-back, so the same pad is never used twice for one line.

A small direct-mapped sequence number store keeps the per-line counters. Each entry is tagged with the compartment that owns it. On a read that hits this store, the engine starts building the pad in the same cycle as the memory fetch. Only one XOR then sits between returning data and the cache. On a read that misses, the engine installs a zeroed counter and runs serially: it fetches first and decrypts afterwards.

The key-driven cipher is replaced by a fixed-latency iterative mixing function. The engine handles one cache operation at a time.

Top module: `otp_engine`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0.
- R2: The pad for key K, line address A and counter S starts from s = K XOR ({S,A} zero-extended, A in bits [ADDR_W-1:0] and S directly above it). It then applies PAD_ROUNDS rounds of s = rotl(s + K, 7) XOR s, with the addition modulo 2^LINE_W. A write-back (`req_write`=1) places plaintext XOR pad on `mem_req_wdata`, with `mem_req_write`=1. The cache-side `rsp_valid` pulses in that same cycle.
- R3: Every write-back advances the line's counter by one before the pad is formed. A line that is absent from the store starts at 0, so its first write-back uses 1. Two write-backs of the same plaintext therefore give different ciphertexts.
- R4: A read that hits the store (same line and same compartment ID) issues the memory fetch and starts the pad in the same cycle. It returns the memory word XOR pad(counter held) on `rsp_rdata`, with `rsp_otp`=1.
- R5: Let c be the cycle in which a read-hit fetch is visible on `mem_req_valid`, and let the memory word arrive L cycles after that. The response is then visible max(PAD_ROUNDS+1, L)+1 cycles after c. The engine waits for whichever of pad or data arrives later.
- R6: A read miss installs a counter of 0 for that line and compartment. The pad starts only once memory data has arrived, so the response arrives L+PAD_ROUNDS+2 cycles after the fetch, with `rsp_otp`=0. The returned word is the memory word XOR pad(0).
- R7: Entries carry the owning compartment ID. A read of a held line under another `cmp_id` misses and replaces the entry. A later read under the first ID then misses as well.
- R8: The store is direct-mapped on the low log2(SNC_ENTRIES) bits of the line address. A line with the same index but a different upper address evicts the resident line, and the evicted line's next read misses.
- R9: The engine accepts one operation at a time. `req_ready` is 0 from the cycle after acceptance until the response. `rsp_valid` lasts a single cycle and is only raised while `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_key | input | LINE_W | Key of the current compartment, sampled at acceptance |
| cmp_id | input | ID_W | Current compartment ID, sampled at acceptance |
| req_valid | input | 1 | Cache request present |
| req_write | input | 1 | 1 = write-back, 0 = line read |
| req_addr | input | ADDR_W | Virtual line address |
| req_wdata | input | LINE_W | Plaintext line for write-back |
| req_ready | output | 1 | Engine idle; a request is taken at this edge |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | LINE_W | Decrypted line on reads, zero on writes |
| rsp_otp | output | 1 | 1 when the overlapped pad path was used |
| mem_req_valid | output | 1 | One-cycle memory command |
| mem_req_write | output | 1 | 1 = store ciphertext, 0 = fetch |
| mem_req_addr | output | ADDR_W | Line address toward memory |
| mem_req_wdata | output | LINE_W | Ciphertext for stores |
| mem_rsp_valid | input | 1 | Fetch data present for one cycle |
| mem_rsp_rdata | input | LINE_W | Fetched ciphertext |

## Verification
The assertions assume the following about the inputs. Memory answers every fetch exactly once, with a one-cycle `mem_rsp_valid` pulse, at least one cycle after the fetch appears. No memory response arrives while no fetch is outstanding. The bench's memory model keeps to this: it holds a single outstanding fetch, waits a programmed latency of one or more cycles, and returns a single pulse. The driver raises `req_valid` only after the previous operation's response has been seen, so requests never arrive while the engine is busy.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_ISSUE,
        ENG_RD_OVERLAP,
        ENG_RD_FETCH,
        ENG_RD_SERIAL,
        ENG_WR_PAD
    } eng_state_e;

endpackage

// File: rtl/otp_pad_gen.sv
module otp_pad_gen #(
    parameter int LINE_W = 64,
    parameter int ADDR_W = 32,
    parameter int SEQ_W  = 16,
    parameter int ROUNDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LINE_W-1:0] key,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEQ_W-1:0]  seq,
    output logic [LINE_W-1:0] pad,
    output logic              pad_valid
);
    localparam int CNT_W = $clog2(ROUNDS + 1);
    localparam int ROT   = 7;

    typedef struct packed {
        logic [LINE_W-1:0] s;
        logic [LINE_W-1:0] k;
        logic [CNT_W-1:0]  cnt;
        logic              live;
    } pad_reg_t;

    pad_reg_t pg_q, pg_d;

    function automatic logic [LINE_W-1:0] mix_round(input logic [LINE_W-1:0] s,
                                                   input logic [LINE_W-1:0] k);
        logic [LINE_W-1:0] sum;
        logic [LINE_W-1:0] rot;
        sum = s + k;
        rot = (sum << ROT) | (sum >> (LINE_W - ROT));
        return rot ^ s;
    endfunction

    always_comb begin
        pg_d = pg_q;
        if (start) begin
            pg_d.s    = key ^ LINE_W'({seq, addr});
            pg_d.k    = key;
            pg_d.cnt  = CNT_W'(ROUNDS);
            pg_d.live = 1'b1;
        end else if (pg_q.live && (pg_q.cnt != '0)) begin
            pg_d.s   = mix_round(pg_q.s, pg_q.k);
            pg_d.cnt = pg_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pg_q <= '0;
        else        pg_q <= pg_d;
    end

    assign pad       = pg_q.s;
    assign pad_valid = pg_q.live && (pg_q.cnt == '0);

endmodule

// File: rtl/otp_seq_store.sv
module otp_seq_store #(
    parameter int ADDR_W  = 32,
    parameter int SEQ_W   = 16,
    parameter int ID_W    = 4,
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [ID_W-1:0]   lk_id,
    output logic              lk_hit,
    output logic [SEQ_W-1:0]  lk_seq,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [SEQ_W-1:0]  wr_seq
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [ID_W-1:0]  owner;
        logic [SEQ_W-1:0] seq;
    } snc_ent_t;

    snc_ent_t [ENTRIES-1:0] tbl_q, tbl_d;
    snc_ent_t               lk_ent;
    logic [IDX_W-1:0]       lk_idx, wr_idx;

    assign lk_idx = lk_addr[IDX_W-1:0];
    assign wr_idx = wr_addr[IDX_W-1:0];
    assign lk_ent = tbl_q[lk_idx];

    assign lk_hit = lk_ent.vld && (lk_ent.tag == lk_addr[ADDR_W-1:IDX_W])
                    && (lk_ent.owner == lk_id);
    assign lk_seq = lk_ent.seq;

    always_comb begin
        tbl_d = tbl_q;
        for (int e = 0; e < ENTRIES; e++) begin
            if (wr_en && (wr_idx == IDX_W'(e))) begin
                tbl_d[e].vld   = 1'b1;
                tbl_d[e].tag   = wr_addr[ADDR_W-1:IDX_W];
                tbl_d[e].owner = wr_id;
                tbl_d[e].seq   = wr_seq;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

endmodule

// File: rtl/otp_engine.sv
module otp_engine
    import otp_pkg::*;
#(
    parameter int LINE_W      = 64,
    parameter int ADDR_W      = 32,
    parameter int SEQ_W       = 16,
    parameter int ID_W        = 4,
    parameter int SNC_ENTRIES = 8,
    parameter int PAD_ROUNDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] cmp_key,
    input  logic [ID_W-1:0]   cmp_id,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LINE_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [LINE_W-1:0] rsp_rdata,
    output logic              rsp_otp,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [LINE_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rsp_rdata
);
    typedef struct packed {
        eng_state_e        st;
        logic              op_wr;
        logic              hit;
        logic [ADDR_W-1:0] addr;
        logic [LINE_W-1:0] wdata;
        logic [LINE_W-1:0] key;
        logic [SEQ_W-1:0]  seq;
        logic              have_data;
        logic [LINE_W-1:0] data;
        logic              rsp_v;
        logic [LINE_W-1:0] rsp_data;
        logic              rsp_fast;
        logic              mv;
        logic              mw;
        logic [LINE_W-1:0] mwdata;
    } eng_reg_t;

    eng_reg_t st_q, st_d;

    logic              lk_hit;
    logic [SEQ_W-1:0]  lk_seq;
    logic              snc_we;
    logic [SEQ_W-1:0]  snc_wseq;
    logic              pad_start;
    logic              pad_valid;
    logic [LINE_W-1:0] pad;
    logic              path_fast;
    logic [LINE_W-1:0] fetched;

    otp_seq_store #(
        .ADDR_W (ADDR_W),
        .SEQ_W  (SEQ_W),
        .ID_W   (ID_W),
        .ENTRIES(SNC_ENTRIES)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_addr(req_addr),
        .lk_id  (cmp_id),
        .lk_hit (lk_hit),
        .lk_seq (lk_seq),
        .wr_en  (snc_we),
        .wr_addr(req_addr),
        .wr_id  (cmp_id),
        .wr_seq (snc_wseq)
    );

    otp_pad_gen #(
        .LINE_W(LINE_W),
        .ADDR_W(ADDR_W),
        .SEQ_W (SEQ_W),
        .ROUNDS(PAD_ROUNDS)
    ) u_pad (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (pad_start),
        .key      (st_q.key),
        .addr     (st_q.addr),
        .seq      (st_q.seq),
        .pad      (pad),
        .pad_valid(pad_valid)
    );

    assign fetched = mem_rsp_valid ? mem_rsp_rdata : st_q.data;

    always_comb begin
        st_d      = st_q;
        st_d.rsp_v = 1'b0;
        st_d.mv    = 1'b0;
        pad_start  = 1'b0;
        snc_we     = 1'b0;
        snc_wseq   = '0;

        unique case (st_q.st)
            ENG_IDLE: begin
                if (req_valid) begin
                    st_d.op_wr     = req_write;
                    st_d.hit       = lk_hit;
                    st_d.addr      = req_addr;
                    st_d.wdata     = req_wdata;
                    st_d.key       = cmp_key;
                    st_d.have_data = 1'b0;
                    if (req_write) begin
                        st_d.seq = (lk_hit ? lk_seq : '0) + SEQ_W'(1);
                        st_d.mv  = 1'b0;
                    end else begin
                        st_d.seq = lk_hit ? lk_seq : '0;
                        st_d.mv  = 1'b1;
                        st_d.mw  = 1'b0;
                    end
                    snc_we   = 1'b1;
                    snc_wseq = st_d.seq;
                    st_d.st  = ENG_ISSUE;
                end
            end
            ENG_ISSUE: begin
                pad_start = st_q.op_wr || st_q.hit;
                if (st_q.op_wr)    st_d.st = ENG_WR_PAD;
                else if (st_q.hit) st_d.st = ENG_RD_OVERLAP;
                else               st_d.st = ENG_RD_FETCH;
            end
            ENG_RD_OVERLAP: begin
                if (mem_rsp_valid) begin
                    st_d.data      = mem_rsp_rdata;
                    st_d.have_data = 1'b1;
                end
                if (pad_valid && (st_q.have_data || mem_rsp_valid)) begin
                    st_d.rsp_v    = 1'b1;
                    st_d.rsp_data = fetched ^ pad;
                    st_d.rsp_fast = 1'b1;
                    st_d.st       = ENG_IDLE;
                end
            end
            ENG_RD_FETCH: begin
                if (mem_rsp_valid) begin
                    st_d.data      = mem_rsp_rdata;
                    st_d.have_data = 1'b1;
                    pad_start      = 1'b1;
                    st_d.st        = ENG_RD_SERIAL;
                end
            end
            ENG_RD_SERIAL: begin
                if (pad_valid) begin
                    st_d.rsp_v    = 1'b1;
                    st_d.rsp_data = st_q.data ^ pad;
                    st_d.rsp_fast = 1'b0;
                    st_d.st       = ENG_IDLE;
                end
            end
            ENG_WR_PAD: begin
                if (pad_valid) begin
                    st_d.mv       = 1'b1;
                    st_d.mw       = 1'b1;
                    st_d.mwdata   = st_q.wdata ^ pad;
                    st_d.rsp_v    = 1'b1;
                    st_d.rsp_data = '0;
                    st_d.rsp_fast = 1'b1;
                    st_d.st       = ENG_IDLE;
                end
            end
            default: st_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready     = (st_q.st == ENG_IDLE);
    assign rsp_valid     = st_q.rsp_v;
    assign rsp_rdata     = st_q.rsp_data;
    assign rsp_otp       = st_q.rsp_fast;
    assign mem_req_valid = st_q.mv;
    assign mem_req_write = st_q.mw;
    assign mem_req_addr  = st_q.addr;
    assign mem_req_wdata = st_q.mwdata;
    assign path_fast     = st_q.hit;

endmodule

// File: rtl/otp_engine_chk.sv
module otp_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_valid,
    input logic mem_req_valid,
    input logic mem_req_write,
    input logic pad_start,
    input logic pad_valid,
    input logic path_fast
);
    assert_one_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_rsp_when_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    assert_pad_with_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write && path_fast) |-> pad_start);

    assert_serial_on_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write && !path_fast) |-> !pad_start);

    assert_store_after_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> $past(pad_valid));

endmodule

bind otp_engine otp_engine_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .mem_req_valid(mem_req_valid),
    .mem_req_write(mem_req_write),
    .pad_start    (pad_start),
    .pad_valid    (pad_valid),
    .path_fast    (path_fast)
);

// File: tb/otp_engine_test.sv
`timescale 1ns/100ps
module otp_engine_test;
    localparam int LW = 64;
    localparam int AW = 32;
    localparam int SW = 16;
    localparam int IW = 4;
    localparam int NR = 4;

    logic          clk, rst_n;
    logic [LW-1:0] cmp_key;
    logic [IW-1:0] cmp_id;
    logic          req_valid, req_write;
    logic [AW-1:0] req_addr;
    logic [LW-1:0] req_wdata;
    logic          req_ready, rsp_valid, rsp_otp;
    logic [LW-1:0] rsp_rdata;
    logic          mem_req_valid, mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [LW-1:0] mem_req_wdata;
    logic          mem_rsp_valid;
    logic [LW-1:0] mem_rsp_rdata;

    otp_engine uut (
        .clk(clk), .rst_n(rst_n), .cmp_key(cmp_key), .cmp_id(cmp_id),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_otp(rsp_otp), .mem_req_valid(mem_req_valid),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    typedef struct {
        bit            is_wr;
        logic [AW-1:0] addr;
        logic [LW-1:0] data;
        bit            fast;
        int            lat;
        string         req;
    } item_t;

    item_t         sb[$];
    logic [LW-1:0] mem_store [logic [AW-1:0]];
    int            checks = 0, fails = 0, done_cnt = 0;
    int            cyc = 0, last_req_cyc = 0, mem_lat = 4;
    bit            finished = 0;
    logic [AW-1:0] rd_addr;

    initial begin
        clk = 1'b0;
        forever #2.5 clk = ~clk;
    end

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [LW-1:0] pad_f(logic [LW-1:0] k, logic [AW-1:0] a, logic [SW-1:0] s);
        logic [LW-1:0] v, sum;
        v = k ^ {16'h0, s, a};
        for (int r = 0; r < NR; r++) begin
            sum = v + k;
            v = {sum[LW-8:0], sum[LW-1:LW-7]} ^ v;
        end
        return v;
    endfunction

    function automatic logic [LW-1:0] mem_get(logic [AW-1:0] a);
        return mem_store.exists(a) ? mem_store[a] : '0;
    endfunction

    task automatic check(bit ok, string req, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model: one outstanding fetch, programmable latency
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_rdata = '0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid && !mem_req_write) begin
                rd_addr = mem_req_addr;
                repeat (mem_lat) @(negedge clk);
                mem_rsp_rdata = mem_get(rd_addr);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // monitor: pops the scoreboard on each completion
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req_valid && !mem_req_write) last_req_cyc = cyc;
            if (mem_req_valid && mem_req_write) mem_store[mem_req_addr] = mem_req_wdata;
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    check(0, "R9", "response with nothing pending", 1, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    if (it.is_wr) begin
                        check(mem_req_valid && mem_req_write, it.req, "store issued with response",
                              LW'({mem_req_valid, mem_req_write}), 3);
                        check(mem_req_addr == it.addr, it.req, "store address", LW'(mem_req_addr), LW'(it.addr));
                        check(mem_req_wdata == it.data, it.req, "ciphertext", mem_req_wdata, it.data);
                    end else begin
                        check(rsp_rdata == it.data, it.req, "read plaintext", rsp_rdata, it.data);
                        check(rsp_otp == it.fast, it.req, "path flag", LW'(rsp_otp), LW'(it.fast));
                        if (it.lat >= 0)
                            check((cyc - last_req_cyc) == it.lat, it.req, "latency",
                                  LW'(cyc - last_req_cyc), LW'(it.lat));
                    end
                end
                done_cnt++;
            end
        end
    end

    task automatic issue(bit wr, logic [AW-1:0] a, logic [LW-1:0] d, logic [IW-1:0] id,
                         logic [LW-1:0] k, int lat);
        int target;
        target  = done_cnt + 1;
        mem_lat = lat;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        cmp_id = id; cmp_key = k;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R9", "busy after accept", LW'(req_ready), 0);
        wait (done_cnt == target);
    endtask

    task automatic wr_line(logic [AW-1:0] a, logic [LW-1:0] d, logic [IW-1:0] id,
                           logic [LW-1:0] k, logic [SW-1:0] seq, string req);
        item_t it;
        it.is_wr = 1; it.addr = a; it.data = d ^ pad_f(k, a, seq);
        it.fast = 1; it.lat = -1; it.req = req;
        sb.push_back(it);
        issue(1'b1, a, d, id, k, 1);
    endtask

    task automatic rd_line(logic [AW-1:0] a, logic [IW-1:0] id, logic [LW-1:0] k, int lat,
                           logic [LW-1:0] exp, bit fast, int exp_lat, string req);
        item_t it;
        it.is_wr = 0; it.addr = a; it.data = exp; it.fast = fast;
        it.lat = exp_lat; it.req = req;
        sb.push_back(it);
        issue(1'b0, a, '0, id, k, lat);
    endtask

    function automatic int hit_lat(int l);
        return ((NR + 1) > l ? (NR + 1) : l) + 1;
    endfunction

    localparam logic [LW-1:0] K1 = 64'h0123_4567_89AB_CDEF;
    localparam logic [LW-1:0] K2 = 64'hF00D_BEEF_1357_2468;
    localparam logic [LW-1:0] P1 = 64'hDEAD_0000_CAFE_1111;
    localparam logic [LW-1:0] P3 = 64'h5555_AAAA_3333_CCCC;
    localparam logic [AW-1:0] LA = 32'h0000_0100;
    localparam logic [AW-1:0] LB = 32'h0000_0208;

    initial begin
        logic [LW-1:0] c_first;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_wdata = '0; cmp_id = '0; cmp_key = '0;
        mem_store[LB] = 64'h0F0F_1234_5678_9ABC;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "ready after reset", LW'(req_ready), 1);
        check(rsp_valid == 1'b0, "R1", "no response after reset", LW'(rsp_valid), 0);
        check(mem_req_valid == 1'b0, "R1", "no memory command after reset", LW'(mem_req_valid), 0);

        // R2 R3: first write-back of an absent line uses counter 1
        wr_line(LA, P1, 4'd1, K1, 16'd1, "R2");
        c_first = mem_get(LA);
        // R4 R5: read hit, data later than pad
        rd_line(LA, 4'd1, K1, 8, P1, 1, hit_lat(8), "R4");
        // R5: pad later than data
        rd_line(LA, 4'd1, K1, 2, P1, 1, hit_lat(2), "R5");
        // R3: same plaintext again, counter 2, different ciphertext
        wr_line(LA, P1, 4'd1, K1, 16'd2, "R3");
        check(mem_get(LA) != c_first, "R3", "pad reused", mem_get(LA), ~c_first);
        rd_line(LA, 4'd1, K1, 5, P1, 1, hit_lat(5), "R4");
        // R6 R8: conflicting line misses, serial with counter 0
        rd_line(LB, 4'd1, K1, 3, mem_get(LB) ^ pad_f(K1, LB, 16'd0), 0, 3 + NR + 2, "R6");
        // R8: evicted line now misses
        rd_line(LA, 4'd1, K1, 4, mem_get(LA) ^ pad_f(K1, LA, 16'd0), 0, 4 + NR + 2, "R8");
        // R3: reinstalled at 0, write-back moves it to 1
        wr_line(LA, P3, 4'd1, K1, 16'd1, "R3");
        rd_line(LA, 4'd1, K1, 6, P3, 1, hit_lat(6), "R4");
        // R7: other compartment misses and takes the entry
        rd_line(LA, 4'd2, K2, 2, mem_get(LA) ^ pad_f(K2, LA, 16'd0), 0, 2 + NR + 2, "R7");
        rd_line(LA, 4'd2, K2, 7, mem_get(LA) ^ pad_f(K2, LA, 16'd0), 1, hit_lat(7), "R7");
        rd_line(LA, 4'd1, K1, 1, mem_get(LA) ^ pad_f(K1, LA, 16'd0), 0, 1 + NR + 2, "R7");
        // R4 R5: several lines, varied latency
        for (int i = 1; i <= 5; i++) begin
            logic [AW-1:0] a;
            logic [LW-1:0] d;
            a = 32'h0000_0300 + AW'(i);
            d = {32'hA5A5_0000 | i, ~i};
            wr_line(a, d, 4'd3, K2, 16'd1, "R2");
            rd_line(a, 4'd3, K2, 2 * i - 1, d, 1, hit_lat(2 * i - 1), "R5");
        end
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R9", "all operations completed", LW'(sb.size()), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL R9 watchdog expired actual=%0d expected=%0d", done_cnt, done_cnt + 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule